// File: doc/BRIEF.md
# Local Bus Interrupt Controller

This block gathers sixteen level-sensitive interrupt request lines from a local peripheral bus. Each line is captured into a source register that simply follows the line's level. A software-programmable enable mask selects which sources may interrupt. A single combined request output goes high while at least one enabled source is asserted.

Software services the controller through a small 16-bit register window. The enable mask can be read and written at one offset. A second, read-only offset returns a vector that identifies the lowest-numbered enabled source that is active. The vector is encoded so that a value of zero means nothing is pending. An interrupt handler reads this vector, indexes its dispatch table with it, services the device, and reads again until it sees zero.

Top module: `lbus_irq_ctrl`

## Requirements
- R1: Each source bit takes the level of its input line at every clock edge: it is 1 while the line is high and 0 while it is low.
- R2: A source is pending when its source bit and its mask bit are both 1. `irq_out` is high one clock after any input is pending, and low one clock after none is.
- R3: A read at offset 0x00 returns ((index of the lowest-numbered pending source) + 1) << 2. Bit 0 has the highest priority, so its vector is 0x04, and bit 15 gives 0x40. The vector is formed from the source bits as they stand in the read cycle.
- R4: A read at offset 0x00 returns 0 when no source is pending, even if some lines are high but masked.
- R5: Offset 0x02 is the enable mask. A write there stores all 16 bits of `wdata`, and a read returns the stored value.
- R6: A mask write takes effect on `irq_out` at the next clock edge, with no further delay.
- R7: After synchronous reset the mask is 0x0010, all source bits are 0, `irq_out` is low and `rdata` is 0.
- R8: Writes to any offset other than 0x02, including the read-only offset 0x00, leave the mask unchanged.
- R9: Reads of any offset other than 0x00 and 0x02 return 0.
- R10: `rdata` carries read data in the cycle after `rd_en` is sampled high, and it is 0 in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_lines | input | 16 | Level-sensitive interrupt request lines, bit n is source n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Byte offset of the register access |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after a read strobe |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a vector read that falls in the same cycle as a change on the request lines. In that case the vector must reflect the source bits captured at the previous edge, not the new levels. The stimulus drives a new line pattern and the read strobe on the same falling edge, then expects the vector of the old pattern. A follow-up read then expects the vector of the new pattern. A second awkward case is a line that is high but masked: it must hold both the vector and the output at zero, and unmasking it with a single write must raise the output at the very next edge.

// File: rtl/lbus_irq_pkg.sv
// Package: shared register offsets and vector encoding for the local-bus
// interrupt controller. Assumes byte offsets of a 16-bit register window.
package lbus_irq_pkg;

    localparam int OFS_VECTOR = 0;  // read-only vector register
    localparam int OFS_MASK   = 2;  // read/write enable mask
    localparam int VEC_SHIFT  = 2;  // vector is (index + 1) shifted by this

endpackage

// File: rtl/lbus_irq_src.sv
// Module: level tracker. Samples every request line into a source register
// on each clock and registers the combined request from the mask value that
// will be in force after this edge. Assumes the lines are already synchronous.
module lbus_irq_src #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] lines,
    input  logic [N_SRC-1:0] mask_nxt,
    output logic [N_SRC-1:0] src_q,
    output logic             irq_q
);

    // Follow the line levels and form the registered combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            irq_q <= 1'b0;
        end else begin
            src_q <= lines;
            irq_q <= |(lines & mask_nxt);
        end
    end

endmodule

// File: rtl/lbus_irq_prio.sv
// Module: priority encoder. Finds the lowest set bit of the pending vector
// and encodes it as (index + 1) << VEC_SHIFT, or zero if none is set.
// Assumes DATA_W is wide enough to hold the largest vector.
module lbus_irq_prio
    import lbus_irq_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int DATA_W = 16
) (
    input  logic [N_SRC-1:0]  pending,
    output logic [DATA_W-1:0] vector
);

    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [IDX_W-1:0] idx;
    logic             found;

    // Scan from the top so the lowest set bit is the last one kept.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end

    // Encode the winning index; zero stands for nothing pending.
    always_comb begin
        if (found) begin
            vector = (DATA_W'(idx) + DATA_W'(1)) << VEC_SHIFT;
        end else begin
            vector = '0;
        end
    end

endmodule

// File: rtl/lbus_irq_regs.sv
// Module: register window. Holds the enable mask, decodes writes to it,
// and returns read data one cycle after a read strobe (zero otherwise).
// Assumes at most one of wr_en and rd_en is used per access.
module lbus_irq_regs
    import lbus_irq_pkg::*;
#(
    parameter int                 N_SRC      = 16,
    parameter int                 DATA_W     = 16,
    parameter int                 ADDR_W     = 4,
    parameter logic [N_SRC-1:0]   MASK_RESET = 16'h0010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] vector,
    output logic [N_SRC-1:0]  mask_q,
    output logic [N_SRC-1:0]  mask_nxt,
    output logic [DATA_W-1:0] rdata
);

    logic hit_vec;
    logic hit_mask;
    logic [DATA_W-1:0] rd_val;

    assign hit_vec  = (addr == ADDR_W'(OFS_VECTOR));
    assign hit_mask = (addr == ADDR_W'(OFS_MASK));

    // Next mask value: a write to the mask offset replaces it.
    always_comb begin
        mask_nxt = mask_q;
        if (wr_en && hit_mask) begin
            mask_nxt = N_SRC'(wdata);
        end
    end

    // Read multiplexer; unmapped offsets read as zero.
    always_comb begin
        rd_val = '0;
        if (hit_vec) begin
            rd_val = vector;
        end else if (hit_mask) begin
            rd_val = DATA_W'(mask_q);
        end
    end

    // Mask storage and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= MASK_RESET;
            rdata  <= '0;
        end else begin
            mask_q <= mask_nxt;
            rdata  <= rd_en ? rd_val : '0;
        end
    end

endmodule

// File: rtl/lbus_irq_ctrl.sv
// Module: local-bus interrupt controller top. Level-tracks the request
// lines, masks them, drives one combined request and offers a vectored read.
// Assumes synchronous request lines and a synchronous active-low reset.
module lbus_irq_ctrl #(
    parameter int N_SRC  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_lines,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_out
);

    logic [N_SRC-1:0]  src_lvl;
    logic [N_SRC-1:0]  mask_val;
    logic [N_SRC-1:0]  mask_nxt;
    logic [DATA_W-1:0] vec;

    lbus_irq_src #(.N_SRC(N_SRC)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines    (irq_lines),
        .mask_nxt (mask_nxt),
        .src_q    (src_lvl),
        .irq_q    (irq_out)
    );

    lbus_irq_prio #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_prio (
        .pending (src_lvl & mask_val),
        .vector  (vec)
    );

    lbus_irq_regs #(
        .N_SRC      (N_SRC),
        .DATA_W     (DATA_W),
        .ADDR_W     (ADDR_W),
        .MASK_RESET (N_SRC'(16'h0010))
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .vector   (vec),
        .mask_q   (mask_val),
        .mask_nxt (mask_nxt),
        .rdata    (rdata)
    );

endmodule

// File: rtl/lbus_irq_chk.sv
// Module: assertion checker for lbus_irq_ctrl, attached with bind.
// Assumes the synchronous active-low reset of the design it watches.
module lbus_irq_chk
    import lbus_irq_pkg::*;
#(
    parameter int N_SRC  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  irq_lines,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              irq_out,
    input logic [N_SRC-1:0]  src_q,
    input logic [N_SRC-1:0]  mask_q
);

    // Source register holds the line levels of the previous edge.
    assert_src_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> src_q == $past(irq_lines));

    // Combined request agrees with the stored source and mask.
    assert_irq_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> irq_out == |(src_q & mask_q));

    // Nothing pending gives a zero vector.
    assert_vec_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_VECTOR) && (src_q & mask_q) == '0)
        |=> rdata == '0);

    // A mask write stores the written word.
    assert_mask_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_MASK)) |=> mask_q == N_SRC'($past(wdata)));

    // Writes elsewhere leave the mask alone.
    assert_mask_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && addr == ADDR_W'(OFS_MASK))) |=> $stable(mask_q));

    // Unmapped reads return zero.
    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != ADDR_W'(OFS_VECTOR) && addr != ADDR_W'(OFS_MASK))
        |=> rdata == '0);

    // No read strobe, no read data.
    assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);

endmodule

bind lbus_irq_ctrl lbus_irq_chk #(
    .N_SRC  (N_SRC),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .irq_out   (irq_out),
    .src_q     (src_lvl),
    .mask_q    (mask_val)
);

// File: tb/sim_lbus_irq_ctrl.sv
// Bench for lbus_irq_ctrl: a vector table walked by one loop, then directed
// tests for reset and corner cases. Inputs change on falling edges and
// outputs are sampled on falling edges.
module sim_lbus_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_lines = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    logic [15:0] rv;

    always #2 clk = ~clk;  // 250 MHz

    lbus_irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq_out   (irq_out)
    );

    // Table: lines, mask, expected vector, expected irq_out.
    localparam int NV = 8;
    localparam logic [15:0] T_LINES [NV] = '{16'h0001, 16'h8000, 16'h8010, 16'h00F0,
                                             16'h0001, 16'hFFFF, 16'h0C00, 16'hFFFF};
    localparam logic [15:0] T_MASK  [NV] = '{16'hFFFF, 16'hFFFF, 16'h0010, 16'h00C0,
                                             16'hFFFE, 16'h0000, 16'h0F00, 16'h8000};
    localparam logic [15:0] T_VEC   [NV] = '{16'h0004, 16'h0040, 16'h0014, 16'h001C,
                                             16'h0000, 16'h0000, 16'h002C, 16'h0040};
    localparam logic        T_IRQ   [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%04h expected=0x%04h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check("R7 irq_out after reset", {15'd0, irq_out}, 16'h0000);
        check("R7 rdata after reset", rdata, 16'h0000);
        rst_n = 1'b1;
        do_read(4'h2, rv);
        check("R7 mask reset value", rv, 16'h0010);
        do_read(4'h0, rv);
        check("R7 vector after reset", rv, 16'h0000);

        // Table walk: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            do_write(4'h2, T_MASK[i]);
            @(negedge clk);
            irq_lines = T_LINES[i];
            @(negedge clk);
            check("R2 irq_out from table", {15'd0, irq_out}, {15'd0, T_IRQ[i]});
            do_read(4'h0, rv);
            check("R3/R4 vector from table", rv, T_VEC[i]);
            do_read(4'h2, rv);
            check("R5 mask readback", rv, T_MASK[i]);
        end

        // R8: writes to other offsets are ignored
        do_write(4'h2, 16'h00FF);
        do_write(4'h0, 16'h1234);
        do_write(4'h4, 16'hABCD);
        do_write(4'h3, 16'h5555);
        do_read(4'h2, rv);
        check("R8 mask unchanged after stray writes", rv, 16'h00FF);

        // R9: unmapped reads return zero with live state present
        irq_lines = 16'h0001;
        do_read(4'h6, rv);
        check("R9 unmapped read 0x6", rv, 16'h0000);
        do_read(4'h1, rv);
        check("R9 unmapped read 0x1", rv, 16'h0000);

        // R10: rdata is zero in a cycle that does not follow a read
        @(negedge clk);
        check("R10 rdata idle", rdata, 16'h0000);

        // R6: masked line, then unmask with one write -> irq next edge
        do_write(4'h2, 16'h0000);
        @(negedge clk);
        irq_lines = 16'h0020;
        @(negedge clk);
        check("R6 masked line keeps irq low", {15'd0, irq_out}, 16'h0000);
        do_read(4'h0, rv);
        check("R4 masked line gives zero vector", rv, 16'h0000);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h2; wdata = 16'h0020;
        @(negedge clk);
        wr_en = 1'b0;
        check("R6 irq one edge after mask write", {15'd0, irq_out}, 16'h0001);

        // R1: line drops -> source clears -> irq low next edge
        irq_lines = 16'h0000;
        @(negedge clk);
        check("R1 irq low after line drops", {15'd0, irq_out}, 16'h0000);

        // R3: read in the same cycle the lines change sees the old levels
        do_write(4'h2, 16'hFFFF);
        irq_lines = 16'h0100;
        repeat (2) @(negedge clk);
        rd_en = 1'b1; addr = 4'h0; irq_lines = 16'h0002;
        @(negedge clk);
        rd_en = 1'b0;
        check("R3 vector uses levels of previous edge", rdata, 16'h0024);
        do_read(4'h0, rv);
        check("R1/R3 vector after new levels", rv, 16'h0008);

        // R7: reset mid-run restores mask and output
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 irq low in reset", {15'd0, irq_out}, 16'h0000);
        irq_lines = 16'h0000;
        rst_n = 1'b1;
        do_read(4'h2, rv);
        check("R7 mask back to reset value", rv, 16'h0010);

        finish_run();
    end

endmodule